// File: doc/BRIEF.md
# Dual-Clock Configurable RAM

This block is a simple dual-port memory with one write port and one read port. Its storage is a fixed 4096-bit array. The word width is fixed at elaboration to 2, 4, 8 or 16 bits, and the depth follows as 4096 divided by the width. The write port registers its data, address and write enable on an input clock that is qualified by an input clock enable. A one-cycle write strobe derived from those registers then writes the array on the next input-clock edge. Because the read port has its own address, a read and a write can proceed in the same cycle.

The read port registers the read address and the read enable. A parameter decides whether these registers use the input clock and its enable, or the output clock and its enable. The data output is a register on the output clock, qualified by its own output enable. An asynchronous clear input resets every register in the block, but it does not reset the storage array. The physical array has 256 rows of 16 bits. In the narrower widths the low address bits pick a slice within a row.

Top module: `dual_clk_ram`

## Requirements
- R1: Parameter WORD_W accepts 2, 4, 8 or 16. Depth is 4096/WORD_W words and the address is log2(depth) bits wide, so the default WORD_W=8 gives 512 words and a 9-bit address.
- R2: Write address, write data and write enable are captured on a rising edge of in_clk only while in_ce is 1. A write presented while in_ce is 0 leaves the memory unchanged.
- R3: The array is written exactly once, on the in_clk edge that follows an enabled capture with wr_en=1. An asynchronous clear between the two edges cancels that write.
- R4: Reads and writes use separate address inputs, so a read of one location and a write of another can be presented on the same edge.
- R5: With the read registers on the input clock, a read presented before in_clk edge k appears on rd_data after out_clk edge k+1. This holds when both clocks share edges and both enables are 1.
- R6: On an out_clk edge with out_ce=0, rd_data keeps its value.
- R7: When the registered read enable is 0, rd_data keeps its value.
- R8: When a read and a write address the same word on the same array edge, the read returns the contents from before the write.
- R9: In narrow modes the address is {row, slice}: the low log2(16/WORD_W) bits select the slice (slice 0 in the least significant bits). A write to one slice leaves the other slices of the row unchanged.
- R10: With RD_CLK=RD_REGS_OUT_CLK, the read address and read enable are captured on out_clk only while out_ce is 1, so a read address presented while out_ce is 0 is not taken.
- R11: While clr is 1, rd_data is 0 at once, without waiting for a clock edge, and every register is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Input clock for the write registers (and the read registers when selected) |
| in_ce | input | 1 | Enable for the in_clk registers |
| out_clk | input | 1 | Output clock for the data output register (and the read registers when selected) |
| out_ce | input | 1 | Enable for the out_clk registers |
| clr | input | 1 | Asynchronous active-high clear of all registers |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | WORD_W | Write word |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | WORD_W | Registered read word |

## Verification
The main stimulus pattern writes both slices of one row and a word at the top address, then reads each back. A mismatch here separates slice-select errors from row-select errors. A write and a read to one word on the same array edge shows whether the read returns the old contents or the new ones. A read cycle with the enable off distinguishes a held output from a fresh read. Separate runs with each clock enable held low, with a clear placed between the capture of a write and its commit, and on a second instance whose read registers use the output clock, each show that a capture or update happens only on the intended edge.

// File: rtl/dcram_pkg.sv
package dcram_pkg;

    localparam int unsigned ARRAY_BITS = 4096;
    localparam int unsigned ROW_BITS   = 16;
    localparam int unsigned ROW_COUNT  = ARRAY_BITS / ROW_BITS;

    typedef enum logic {
        RD_REGS_IN_CLK  = 1'b0,
        RD_REGS_OUT_CLK = 1'b1
    } rd_clk_sel_e;

    function automatic int unsigned slice_sel_bits(input int unsigned word_w);
        return $clog2(ROW_BITS / word_w);
    endfunction

    function automatic int unsigned word_addr_bits(input int unsigned word_w);
        return $clog2(ARRAY_BITS / word_w);
    endfunction

endpackage

// File: rtl/dcram_wr_port.sv
module dcram_wr_port #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned WORD_W = 8
) (
    input  logic              in_clk,
    input  logic              in_ce,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [ADDR_W-1:0] wa_q,
    output logic [WORD_W-1:0] wd_q,
    output logic              wr_stb
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic              stb;
    } wr_req_t;

    wr_req_t req_q;

    always_ff @(posedge in_clk or posedge clr) begin
        if (clr) begin
            req_q <= '0;
        end else if (in_ce) begin
            req_q <= '{addr: wr_addr, data: wr_data, stb: wr_en};
        end else begin
            req_q.stb <= 1'b0;
        end
    end

    assign wa_q   = req_q.addr;
    assign wd_q   = req_q.data;
    assign wr_stb = req_q.stb;

endmodule

// File: rtl/dcram_rd_port.sv
module dcram_rd_port #(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              rd_clk,
    input  logic              rd_ce,
    input  logic              clr,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] ra_q,
    output logic              re_q
);

    always_ff @(posedge rd_clk or posedge clr) begin
        if (clr) begin
            ra_q <= '0;
            re_q <= 1'b0;
        end else if (rd_ce) begin
            ra_q <= rd_addr;
            re_q <= rd_en;
        end
    end

endmodule

// File: rtl/dcram_core.sv
module dcram_core #(
    parameter int unsigned WORD_W = 8,
    parameter int unsigned ADDR_W = 9
) (
    input  logic              in_clk,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wa_q,
    input  logic [WORD_W-1:0] wd_q,
    input  logic              out_clk,
    input  logic              out_ce,
    input  logic              clr,
    input  logic [ADDR_W-1:0] ra_q,
    input  logic              re_q,
    output logic [WORD_W-1:0] rd_data
);
    import dcram_pkg::*;

    localparam int unsigned SEL_W  = slice_sel_bits(WORD_W);
    localparam int unsigned SW1    = (SEL_W > 0) ? SEL_W : 1;
    localparam int unsigned SLICES = ROW_BITS / WORD_W;
    localparam int unsigned ROW_AW = $clog2(ROW_COUNT);

    logic [ROW_BITS-1:0] mem [ROW_COUNT];

    logic [ROW_AW-1:0] wrow, rrow;
    logic [SW1-1:0]    wsl, rsl;

    assign wrow = wa_q[ADDR_W-1:SEL_W];
    assign rrow = ra_q[ADDR_W-1:SEL_W];

    generate
        if (SEL_W > 0) begin : g_sliced
            assign wsl = wa_q[SW1-1:0];
            assign rsl = ra_q[SW1-1:0];
        end else begin : g_full
            assign wsl = {SW1{1'b0}};
            assign rsl = {SW1{1'b0}};
        end
    endgenerate

    always_ff @(posedge in_clk) begin
        if (wr_stb) begin
            for (int s = 0; s < SLICES; s++) begin
                if (int'(wsl) == s) begin
                    mem[wrow][s*WORD_W +: WORD_W] <= wd_q;
                end
            end
        end
    end

    logic [WORD_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        for (int s = 0; s < SLICES; s++) begin
            if (int'(rsl) == s) begin
                rd_word = mem[rrow][s*WORD_W +: WORD_W];
            end
        end
    end

    always_ff @(posedge out_clk or posedge clr) begin
        if (clr) begin
            rd_data <= '0;
        end else if (out_ce && re_q) begin
            rd_data <= rd_word;
        end
    end

endmodule

// File: rtl/dual_clk_ram.sv
module dual_clk_ram #(
    parameter int unsigned          WORD_W = 8,
    parameter dcram_pkg::rd_clk_sel_e RD_CLK = dcram_pkg::RD_REGS_IN_CLK,
    localparam int unsigned         ADDR_W = dcram_pkg::word_addr_bits(WORD_W)
) (
    input  logic              in_clk,
    input  logic              in_ce,
    input  logic              out_clk,
    input  logic              out_ce,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [ADDR_W-1:0] wa_q;
    logic [WORD_W-1:0] wd_q;
    logic              wr_stb;
    logic [ADDR_W-1:0] ra_q;
    logic              re_q;
    logic              rd_clk;
    logic              rd_ce;

    generate
        if (RD_CLK == dcram_pkg::RD_REGS_OUT_CLK) begin : g_rd_out
            assign rd_clk = out_clk;
            assign rd_ce  = out_ce;
        end else begin : g_rd_in
            assign rd_clk = in_clk;
            assign rd_ce  = in_ce;
        end
    endgenerate

    dcram_wr_port #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wr (
        .in_clk (in_clk),
        .in_ce  (in_ce),
        .clr    (clr),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .wa_q   (wa_q),
        .wd_q   (wd_q),
        .wr_stb (wr_stb)
    );

    dcram_rd_port #(.ADDR_W(ADDR_W)) u_rd (
        .rd_clk (rd_clk),
        .rd_ce  (rd_ce),
        .clr    (clr),
        .rd_en  (rd_en),
        .rd_addr(rd_addr),
        .ra_q   (ra_q),
        .re_q   (re_q)
    );

    dcram_core #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_core (
        .in_clk (in_clk),
        .wr_stb (wr_stb),
        .wa_q   (wa_q),
        .wd_q   (wd_q),
        .out_clk(out_clk),
        .out_ce (out_ce),
        .clr    (clr),
        .ra_q   (ra_q),
        .re_q   (re_q),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/dual_clk_ram_chk.sv
module dual_clk_ram_chk #(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned WORD_W = 8
) (
    input logic              in_clk,
    input logic              in_ce,
    input logic              out_clk,
    input logic              out_ce,
    input logic              clr,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [ADDR_W-1:0] wa_q,
    input logic              wr_stb,
    input logic              re_q,
    input logic [WORD_W-1:0] rd_data
);

    // R11
    always @(posedge out_clk) begin
        if (clr) begin
            clr_zero_chk: assert (rd_data == '0);
        end
    end

    // R6 R7
    rd_hold_chk: assert property (@(posedge out_clk) disable iff (clr)
        !(re_q && out_ce) |=> $stable(rd_data));

    // R2
    wr_capture_chk: assert property (@(posedge in_clk) disable iff (clr)
        in_ce |=> (wa_q == $past(wr_addr)));

    // R3
    wr_single_chk: assert property (@(posedge in_clk) disable iff (clr)
        !in_ce |=> !wr_stb);

    // R2
    wr_hold_chk: assert property (@(posedge in_clk) disable iff (clr)
        !in_ce |=> $stable(wa_q));

endmodule

bind dual_clk_ram dual_clk_ram_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
    .in_clk (in_clk),
    .in_ce  (in_ce),
    .out_clk(out_clk),
    .out_ce (out_ce),
    .clr    (clr),
    .wr_addr(wr_addr),
    .wa_q   (wa_q),
    .wr_stb (wr_stb),
    .re_q   (re_q),
    .rd_data(rd_data)
);

// File: tb/tb_dual_clk_ram.sv
module tb_dual_clk_ram;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       clr = 1'b1;
    logic       ice = 1'b0, oce = 1'b0;
    logic       we = 1'b0, re = 1'b0;
    logic [8:0] wa = '0, ra = '0;
    logic [7:0] wd = '0;
    logic [7:0] dout;

    logic        oce2 = 1'b0;
    logic        we2 = 1'b0, re2 = 1'b0;
    logic [7:0]  wa2 = '0, ra2 = '0;
    logic [15:0] wd2 = '0;
    logic [15:0] dout2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // R1: default width 8 gives a 9-bit address and 512 words
    dual_clk_ram dut (
        .in_clk(clk), .in_ce(ice), .out_clk(clk), .out_ce(oce), .clr(clr),
        .wr_en(we), .wr_addr(wa), .wr_data(wd),
        .rd_en(re), .rd_addr(ra), .rd_data(dout)
    );

    // R1: 16-bit words give 256 words; R10 read registers on out clock
    dual_clk_ram #(.WORD_W(16), .RD_CLK(dcram_pkg::RD_REGS_OUT_CLK)) dut2 (
        .in_clk(clk), .in_ce(1'b1), .out_clk(clk), .out_ce(oce2), .clr(clr),
        .wr_en(we2), .wr_addr(wa2), .wr_data(wd2),
        .rd_en(re2), .rd_addr(ra2), .rd_data(dout2)
    );

    typedef struct packed {
        logic       we;
        logic [8:0] wa;
        logic [7:0] wd;
        logic       re;
        logic [8:0] ra;
        logic       chk;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 9'h004, 8'hA1, 1'b0, 9'h000, 1'b0, 8'h00},
        '{1'b1, 9'h005, 8'hB2, 1'b0, 9'h000, 1'b0, 8'h00},
        '{1'b1, 9'h1FF, 8'hC3, 1'b1, 9'h004, 1'b0, 8'h00},
        '{1'b0, 9'h000, 8'h00, 1'b1, 9'h005, 1'b1, 8'hA1},
        '{1'b0, 9'h000, 8'h00, 1'b1, 9'h1FF, 1'b1, 8'hB2},
        '{1'b1, 9'h004, 8'h5E, 1'b1, 9'h004, 1'b1, 8'hC3},
        '{1'b0, 9'h000, 8'h00, 1'b0, 9'h000, 1'b1, 8'hA1},
        '{1'b0, 9'h000, 8'h00, 1'b1, 9'h004, 1'b1, 8'hA1},
        '{1'b0, 9'h000, 8'h00, 1'b1, 9'h005, 1'b1, 8'h5E},
        '{1'b0, 9'h000, 8'h00, 1'b1, 9'h1FF, 1'b1, 8'hB2},
        '{1'b0, 9'h000, 8'h00, 1'b0, 9'h000, 1'b1, 8'hC3}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic [8:0] a, input logic [7:0] d,
                        input logic r, input logic [8:0] b, input logic ie, input logic oe);
        we = w; wa = a; wd = d; re = r; ra = b; ice = ie; oce = oe;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step2(input logic w, input logic [7:0] a, input logic [15:0] d,
                         input logic r, input logic [7:0] b, input logic oe);
        we2 = w; wa2 = a; wd2 = d; re2 = r; ra2 = b; oce2 = oe;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset state", {8'h00, dout}, 16'h0000);
        check("R11 reset state wide", dout2, 16'h0000);
        clr = 1'b0;
        @(negedge clk);

        // R4 R5 R8 R7 R9 table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].we, VEC[i].wa, VEC[i].wd, VEC[i].re, VEC[i].ra, 1'b1, 1'b1);
            if (VEC[i].chk)
                check($sformatf("R4/R5/R7/R8/R9 vector %0d", i), {8'h00, dout}, {8'h00, VEC[i].exp});
        end

        // R2: write while in_ce is low is dropped
        step(1'b1, 9'h004, 8'h77, 1'b0, 9'h000, 1'b0, 1'b1);
        step(1'b0, 9'h000, 8'h00, 1'b1, 9'h004, 1'b1, 1'b1);
        step(1'b0, 9'h000, 8'h00, 1'b0, 9'h000, 1'b1, 1'b1);
        check("R2 gated write ignored", {8'h00, dout}, 16'h005E);

        // R6: out_ce low holds the output
        step(1'b0, 9'h000, 8'h00, 1'b1, 9'h1FF, 1'b1, 1'b1);
        step(1'b0, 9'h000, 8'h00, 1'b1, 9'h1FF, 1'b1, 1'b0);
        check("R6 out_ce low holds", {8'h00, dout}, 16'h005E);
        step(1'b0, 9'h000, 8'h00, 1'b0, 9'h000, 1'b1, 1'b1);
        check("R6 out_ce high updates", {8'h00, dout}, 16'h00C3);

        // R3 R11: clear between capture and commit cancels the write
        step(1'b1, 9'h005, 8'h99, 1'b0, 9'h000, 1'b1, 1'b1);
        we = 1'b0;
        clr = 1'b1;
        #1;
        check("R11 async clear zeroes output", {8'h00, dout}, 16'h0000);
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
        step(1'b0, 9'h000, 8'h00, 1'b1, 9'h005, 1'b1, 1'b1);
        step(1'b0, 9'h000, 8'h00, 1'b0, 9'h000, 1'b1, 1'b1);
        check("R3 cleared write cancelled", {8'h00, dout}, 16'h00B2);

        // R10: read registers on the output clock
        step2(1'b1, 8'h01, 16'h1111, 1'b0, 8'h00, 1'b1);
        step2(1'b1, 8'h02, 16'h2222, 1'b0, 8'h00, 1'b1);
        step2(1'b0, 8'h00, 16'h0000, 1'b1, 8'h01, 1'b1);
        step2(1'b0, 8'h00, 16'h0000, 1'b1, 8'h02, 1'b0);
        step2(1'b0, 8'h00, 16'h0000, 1'b1, 8'h02, 1'b0);
        step2(1'b0, 8'h00, 16'h0000, 1'b1, 8'h03, 1'b1);
        check("R10 read address held while out_ce low", dout2, 16'h1111);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule